// File: doc/BRIEF.md
# Heartbeat Loss Supervisor with Retry

This block watches periodic heartbeat strobes from the other nodes on a shared management bus. Each watched node has its own silence counter. When some nodes go quiet while at least one other node is still heard, the block emits a one-cycle event that names each silent node. The event says that node was removed or has failed. When every watched node goes quiet together, the block blames its own bus interface rather than the peers.

In that case the block runs a recovery sequence. It cuts itself off the bus and logs the fault. It then pulses a reset into its local bus controller, reconnects, and gives the bus one listening window. A heartbeat from any watched node during that window returns the block to normal supervision. If the window passes in silence, the block disconnects for good, logs a retry failure and lights a latched alarm. Only an explicit clear input takes the alarm down.

The node count, the silence limit, the reset pulse length and the retry window are all parameters. The block's own slot is excluded from monitoring.

Top module: `hb_supervisor`

## Requirements
- R1: After reset, `iso_o`, `ctrl_rst_o`, `evt_valid_o` and `alarm_o` are all low.
- R2: If a watched node's strobe is last sampled at edge k and the node stays silent, `evt_valid_o` is high for exactly one cycle after edge k+TIMEOUT_CYC+1, with `evt_code_o` = 1 (node lost) and `evt_node_o` = that node's index. This happens only while another watched node is still heard. `iso_o` stays low. A node that remains silent is reported only once.
- R3: The strobe at index SELF_IDX has no effect. It keeps no timer alive, it does not count as a heartbeat in the retry window, and a node-lost event never names SELF_IDX.
- R4: If several watched nodes time out in the same cycle (and not all of them), one node-lost event is emitted per cycle, lowest index first.
- R5: When all watched nodes are timed out, `iso_o` rises one cycle later. In that same cycle a one-cycle event with `evt_code_o` = 2 (all lost) and `evt_node_o` = SELF_IDX is emitted. No node-lost event is emitted for that loss.
- R6: The cycle after isolation begins, `ctrl_rst_o` is high for exactly RST_CYC cycles while `iso_o` stays high.
- R7: When the reset pulse ends, `iso_o` drops and a window of RETRY_CYC cycles opens. A strobe from any watched node in that window ends the sequence, and normal supervision resumes with fresh timers, `iso_o` low and no alarm.
- R8: If no watched strobe is sampled during the window, then after RETRY_CYC cycles `iso_o` and `alarm_o` go high together with a one-cycle event of `evt_code_o` = 3 (retry failed) and `evt_node_o` = SELF_IDX.
- R9: Once lit, the alarm and the isolation stay on regardless of heartbeats until `alarm_clr_i` is sampled high. Both then drop in the next cycle and supervision restarts.
- R10: A watched strobe sampled on the very edge at which the retry window expires counts as recovery: no alarm and no retry-failed event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_i | input | NODES | One heartbeat strobe per node slot |
| alarm_clr_i | input | 1 | Manual clear of the latched alarm |
| iso_o | output | 1 | High to disconnect the local interface from the bus |
| ctrl_rst_o | output | 1 | Reset pulse to the local bus controller |
| evt_valid_o | output | 1 | One-cycle qualifier of the event fields |
| evt_code_o | output | 2 | Event kind: 1 node lost, 2 all lost, 3 retry failed |
| evt_node_o | output | $clog2(NODES) | Node index carried with the event |
| alarm_o | output | 1 | Latched alarm indicator |

## Verification
Two decisions can fall on the same clock edge: the expiry of the retry window and the arrival of a recovery heartbeat. The bench provokes this by raising a watched strobe exactly one cycle before expiry, timed from the cycle in which all strobes were dropped. It then judges that the alarm, the isolation and the retry-failed event all stay off. The second collision occurs when several nodes expire on one edge. The bench checks the lowest-first, one-per-cycle ordering of the node-lost events. It also checks that when every watched node expires together, only the all-lost event appears.

// File: rtl/hbs_pkg.sv
package hbs_pkg;
  typedef enum logic [1:0] {
    EVT_NONE       = 2'd0,
    EVT_NODE_LOST  = 2'd1,
    EVT_ALL_LOST   = 2'd2,
    EVT_RETRY_FAIL = 2'd3
  } hbs_evt_e;

  typedef enum logic [2:0] {
    ST_MON   = 3'd0,
    ST_ISO   = 3'd1,
    ST_RST   = 3'd2,
    ST_RETRY = 3'd3,
    ST_FAIL  = 3'd4
  } hbs_state_e;
endpackage

// File: rtl/hbs_node_timer.sv
module hbs_node_timer #(
  parameter int TIMEOUT_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic hb_i,
  output logic lost_o
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_n  = cnt_q;
    if (clr_i || hb_i) begin
      cnt_en = 1'b1;
      cnt_n  = '0;
    end else if (cnt_q != LIMIT) begin
      cnt_en = 1'b1;
      cnt_n  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign lost_o = (cnt_q == LIMIT);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT); // R2
endmodule

// File: rtl/hbs_seq.sv
module hbs_seq
  import hbs_pkg::*;
#(
  parameter int NODES     = 4,
  parameter int SELF_IDX  = 0,
  parameter int RST_CYC   = 4,
  parameter int RETRY_CYC = 30
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NODES-1:0]         lost_i,
  input  logic [NODES-1:0]         hb_i,
  input  logic                     alarm_clr_i,
  output logic                     tmr_clr_o,
  output logic                     iso_o,
  output logic                     ctrl_rst_o,
  output logic                     evt_valid_o,
  output logic [1:0]               evt_code_o,
  output logic [$clog2(NODES)-1:0] evt_node_o,
  output logic                     alarm_o
);
  localparam int IDXW = $clog2(NODES);
  localparam int MAXC = (RETRY_CYC > RST_CYC) ? RETRY_CYC : RST_CYC;
  localparam int CNTW = $clog2(MAXC + 1);
  localparam logic [NODES-1:0] SELF_MASK = {{(NODES-1){1'b0}}, 1'b1} << SELF_IDX;
  localparam logic [IDXW-1:0]  SELF_ID   = IDXW'(SELF_IDX);

  hbs_state_e      st_q, st_n;
  logic [CNTW-1:0] cnt_q, cnt_n;
  logic [NODES-1:0] rep_q, rep_n;
  logic            ev_v_q, ev_v_n;
  hbs_evt_e        ev_c_q, ev_c_n;
  logic [IDXW-1:0] ev_n_q, ev_n_n;
  logic            alarm_q, alarm_n;

  logic            all_lost;
  logic [NODES-1:0] pend;
  logic            found;
  logic [IDXW-1:0] pick;

  assign all_lost = &(lost_i | SELF_MASK);
  assign pend     = lost_i & ~rep_q;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = NODES - 1; i >= 0; i--) begin
      if (pend[i]) begin
        found = 1'b1;
        pick  = IDXW'(i);
      end
    end
  end

  always_comb begin
    st_n    = st_q;
    cnt_n   = cnt_q;
    rep_n   = rep_q & lost_i;
    ev_v_n  = 1'b0;
    ev_c_n  = ev_c_q;
    ev_n_n  = ev_n_q;
    alarm_n = alarm_q;
    case (st_q)
      ST_MON: begin
        if (all_lost) begin
          st_n   = ST_ISO;
          ev_v_n = 1'b1;
          ev_c_n = EVT_ALL_LOST;
          ev_n_n = SELF_ID;
          rep_n  = '0;
        end else if (found) begin
          ev_v_n      = 1'b1;
          ev_c_n      = EVT_NODE_LOST;
          ev_n_n      = pick;
          rep_n[pick] = 1'b1;
        end
      end
      ST_ISO: begin
        st_n  = ST_RST;
        cnt_n = '0;
      end
      ST_RST: begin
        if (cnt_q == CNTW'(RST_CYC - 1)) begin
          st_n  = ST_RETRY;
          cnt_n = '0;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      ST_RETRY: begin
        if (|hb_i) begin
          st_n = ST_MON;
        end else if (cnt_q == CNTW'(RETRY_CYC - 1)) begin
          st_n    = ST_FAIL;
          ev_v_n  = 1'b1;
          ev_c_n  = EVT_RETRY_FAIL;
          ev_n_n  = SELF_ID;
          alarm_n = 1'b1;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      ST_FAIL: begin
        if (alarm_clr_i) begin
          st_n    = ST_MON;
          alarm_n = 1'b0;
        end
      end
      default: st_n = ST_MON;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_MON;
      cnt_q   <= '0;
      rep_q   <= '0;
      ev_v_q  <= 1'b0;
      ev_c_q  <= EVT_NONE;
      ev_n_q  <= '0;
      alarm_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      cnt_q   <= cnt_n;
      rep_q   <= rep_n;
      ev_v_q  <= ev_v_n;
      alarm_q <= alarm_n;
      if (ev_v_n) begin
        ev_c_q <= ev_c_n;
        ev_n_q <= ev_n_n;
      end
    end
  end

  assign tmr_clr_o   = (st_q != ST_MON);
  assign iso_o       = (st_q == ST_ISO) || (st_q == ST_RST) || (st_q == ST_FAIL);
  assign ctrl_rst_o  = (st_q == ST_RST);
  assign evt_valid_o = ev_v_q;
  assign evt_code_o  = ev_c_q;
  assign evt_node_o  = ev_n_q;
  assign alarm_o     = alarm_q;

  AST_RST_AFTER_ISO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_rst_o) |-> $past(iso_o)); // R6
  AST_ALARM_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_o && !alarm_clr_i) |=> alarm_o); // R9
  AST_ALL_LOST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid_o && evt_code_o == EVT_ALL_LOST) |=> !evt_valid_o); // R5
  AST_SELF_NOT_NAMED: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid_o && evt_code_o == EVT_NODE_LOST) |-> (evt_node_o != SELF_ID)); // R3
  AST_FAIL_ON_SILENCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_o) |-> ($past(hb_i) == '0)); // R10
endmodule

// File: rtl/hb_supervisor.sv
module hb_supervisor #(
  parameter int NODES       = 4,
  parameter int SELF_IDX    = 0,
  parameter int TIMEOUT_CYC = 20,
  parameter int RST_CYC     = 4,
  parameter int RETRY_CYC   = 30
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NODES-1:0]         hb_i,
  input  logic                     alarm_clr_i,
  output logic                     iso_o,
  output logic                     ctrl_rst_o,
  output logic                     evt_valid_o,
  output logic [1:0]               evt_code_o,
  output logic [$clog2(NODES)-1:0] evt_node_o,
  output logic                     alarm_o
);
  localparam logic [NODES-1:0] WATCH_MASK = ~({{(NODES-1){1'b0}}, 1'b1} << SELF_IDX);

  logic [NODES-1:0] lost_raw;
  logic [NODES-1:0] lost_w;
  logic [NODES-1:0] hb_w;
  logic             tmr_clr;

  genvar g;
  generate
    for (g = 0; g < NODES; g++) begin : g_tmr
      hbs_node_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) i_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (tmr_clr),
        .hb_i   (hb_i[g]),
        .lost_o (lost_raw[g])
      );
    end
  endgenerate

  assign lost_w = lost_raw & WATCH_MASK;
  assign hb_w   = hb_i & WATCH_MASK;

  hbs_seq #(
    .NODES     (NODES),
    .SELF_IDX  (SELF_IDX),
    .RST_CYC   (RST_CYC),
    .RETRY_CYC (RETRY_CYC)
  ) i_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .lost_i      (lost_w),
    .hb_i        (hb_w),
    .alarm_clr_i (alarm_clr_i),
    .tmr_clr_o   (tmr_clr),
    .iso_o       (iso_o),
    .ctrl_rst_o  (ctrl_rst_o),
    .evt_valid_o (evt_valid_o),
    .evt_code_o  (evt_code_o),
    .evt_node_o  (evt_node_o),
    .alarm_o     (alarm_o)
  );

  AST_PARTIAL_NO_ISO: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid_o && evt_code_o == 2'd1) |-> !iso_o); // R2
endmodule

// File: tb/test_hb_supervisor.sv
`timescale 1ns/1ps
module test_hb_supervisor;
  localparam int N = 4;
  localparam int T = 20;
  localparam int P = 4;
  localparam int W = 30;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] hb_i;
  logic         alarm_clr_i;
  logic         iso_o, ctrl_rst_o, evt_valid_o, alarm_o;
  logic [1:0]   evt_code_o;
  logic [1:0]   evt_node_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  hb_supervisor i_hb_supervisor (
    .clk(clk), .rst_n(rst_n), .hb_i(hb_i), .alarm_clr_i(alarm_clr_i),
    .iso_o(iso_o), .ctrl_rst_o(ctrl_rst_o), .evt_valid_o(evt_valid_o),
    .evt_code_o(evt_code_o), .evt_node_o(evt_node_o), .alarm_o(alarm_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; hb_i = '0; alarm_clr_i = 1'b0;
    repeat (3) tick();
    chk("R1 iso", iso_o, 0);
    chk("R1 ctrl_rst", ctrl_rst_o, 0);
    chk("R1 evt_valid", evt_valid_o, 0);
    chk("R1 alarm", alarm_o, 0);
    rst_n = 1'b1;
    hb_i = 4'b1110;
    repeat (3) tick();
  endtask

  task automatic t_single_loss();
    int ev = 0;
    hb_i = 4'b1010;
    for (int k = 0; k < T; k++) begin tick(); ev += evt_valid_o; end
    chk("R2 no early event", ev, 0);
    tick();
    chk("R2 valid", evt_valid_o, 1);
    chk("R2 code", evt_code_o, 1);
    chk("R2 node", evt_node_o, 2);
    chk("R2 no iso", iso_o, 0);
    tick();
    chk("R2 one cycle", evt_valid_o, 0);
    ev = 0;
    for (int k = 0; k < 10; k++) begin tick(); ev += evt_valid_o; end
    chk("R2 reported once", ev, 0);
    hb_i = 4'b1110;
    repeat (3) tick();
  endtask

  task automatic t_multi_loss();
    hb_i = 4'b0100;
    repeat (T + 1) tick();
    chk("R4 first valid", evt_valid_o, 1);
    chk("R4 first node", evt_node_o, 1);
    tick();
    chk("R4 second valid", evt_valid_o, 1);
    chk("R4 second node", evt_node_o, 3);
    tick();
    chk("R4 done", evt_valid_o, 0);
    hb_i = 4'b1110;
    repeat (3) tick();
  endtask

  task automatic t_all_lost_recover();
    int ev = 0;
    int hi = 0;
    hb_i = 4'b0001;
    for (int k = 0; k < T; k++) begin tick(); ev += evt_valid_o; end
    chk("R3 R5 no node events", ev, 0);
    chk("R5 not yet isolated", iso_o, 0);
    tick();
    chk("R5 iso", iso_o, 1);
    chk("R5 valid", evt_valid_o, 1);
    chk("R5 code", evt_code_o, 2);
    chk("R5 node", evt_node_o, 0);
    for (int k = 0; k < P; k++) begin
      tick();
      hi += ctrl_rst_o;
      chk("R6 iso during reset", iso_o, 1);
    end
    chk("R6 pulse length", hi, P);
    tick();
    chk("R6 pulse ended", ctrl_rst_o, 0);
    chk("R7 reconnected", iso_o, 0);
    repeat (5) tick();
    hb_i = 4'b0100;
    tick();
    hb_i = 4'b1110;
    ev = 0;
    for (int k = 0; k < W + 5; k++) begin tick(); ev += evt_valid_o; end
    chk("R7 no alarm", alarm_o, 0);
    chk("R7 no iso", iso_o, 0);
    chk("R7 no events", ev, 0);
  endtask

  task automatic t_retry_fail();
    int ev = 0;
    hb_i = 4'b0000;
    repeat (T + 1 + P + W) tick();
    chk("R8 alarm before expiry", alarm_o, 0);
    chk("R8 iso before expiry", iso_o, 0);
    tick();
    chk("R8 alarm", alarm_o, 1);
    chk("R8 iso", iso_o, 1);
    chk("R8 valid", evt_valid_o, 1);
    chk("R8 code", evt_code_o, 3);
    chk("R8 node", evt_node_o, 0);
    hb_i = 4'b1110;
    repeat (10) tick();
    chk("R9 alarm held", alarm_o, 1);
    chk("R9 iso held", iso_o, 1);
    alarm_clr_i = 1'b1;
    tick();
    alarm_clr_i = 1'b0;
    chk("R9 alarm cleared", alarm_o, 0);
    chk("R9 iso released", iso_o, 0);
    for (int k = 0; k < T + 5; k++) begin tick(); ev += evt_valid_o; end
    chk("R9 monitoring quiet", ev, 0);
  endtask

  task automatic t_tie();
    int ev = 0;
    hb_i = 4'b0000;
    repeat (T + 1 + P + W) tick();
    hb_i = 4'b0010;
    tick();
    chk("R10 alarm", alarm_o, 0);
    chk("R10 iso", iso_o, 0);
    chk("R10 no event", evt_valid_o, 0);
    hb_i = 4'b1110;
    for (int k = 0; k < W + 5; k++) begin tick(); ev += evt_valid_o; end
    chk("R10 stays normal", ev + alarm_o, 0);
  endtask

  initial begin
    t_reset();
    t_single_loss();
    t_multi_loss();
    t_all_lost_recover();
    t_retry_fail();
    t_tie();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule